// File: doc/BRIEF.md
# Serial DAC Host Write Sequencer

This block is the host-side master for a 12-bit voltage-output DAC that listens on a four-wire frame-synchronised serial port. It takes a 16-bit command from a request port and plays it out as one frame on chip select, frame sync, serial clock and serial data. Every interval of the frame is counted in system clock cycles, so one set of parameters covers any system clock rate. The intervals are the chip-select lead, the frame-sync lead, the clock high and low phases, the tail after the last clock edge and the frame-sync idle pulse. Each count is the nanosecond figure divided by the clock period and rounded up.

A request either sends its word as it stands, or uses configured mode. In configured mode the block builds two frames to the same chip select. The first is a control-register write that carries the speed, power and reference-source selection. The second is a data write with the same speed and power bits and the 12-bit code. A split flag holds the serial clock high for an extra pause after the eighth bit, as a host with an 8-bit shifter would do between its two byte writes. The frame stays open through the pause. A single-cycle done pulse follows once chip select has returned high and the frame-sync idle pulse has elapsed.

Top module: `dacSerialHost`

## Requirements
- R1: After reset and while idle: csN = 2'b11, fs = 1, sclk = 1, sdo = 0, reqReady = 1, done = 0.
- R2: reqReady is 1 only while idle. A request is taken on a clock edge where reqValid and reqReady are both 1. reqValid while busy is ignored and leaves the frame in progress unchanged.
- R3: Only the selected chip select goes low (reqSel = 0 drives csN[0], reqSel = 1 drives csN[1]). It goes low on the cycle after acceptance and leads the falling edge of fs by CS_LEAD_CYC cycles.
- R4: fs stays low FS_LEAD_CYC cycles before the first falling sclk edge, and bit 15 of the word is already on sdo when fs falls.
- R5: Each frame has exactly 16 falling sclk edges. sclk is low for CLK_LOW_CYC cycles and high for CLK_HIGH_CYC cycles.
- R6: Data goes out MSB first. sdo changes only with a rising sclk edge, so it is steady across every falling edge.
- R7: After the 16th rising sclk edge, fs and chip select stay low for TAIL_CYC cycles and then rise on the same cycle. sdo is 0 from that rising edge on.
- R8: fs stays high for FS_IDLE_CYC cycles after each frame. done is then 1 for one cycle with chip select high, and reqReady is 1 in that cycle.
- R9: With reqCfg = 1, two frames go to the same chip select. The first word is {1, speed, power, 1, 10'b0, refSel[1:0]} and the second is {0, speed, power, 0, reqWord[11:0]} (bit 15 first).
- R10: With reqSplit = 1, the high phase after the 8th rising sclk edge lasts CLK_HIGH_CYC + BYTE_GAP_CYC cycles, and fs stays low through it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle, request can be taken |
| reqCfg | input | 1 | 1: control frame then data frame; 0: raw word |
| reqSplit | input | 1 | Pause the clock after the first byte |
| reqSel | input | 1 | Chip select index |
| reqWord | input | 16 | Raw word, or the data code in bits 11..0 |
| reqSpeed | input | 1 | Speed bit for configured mode |
| reqPower | input | 1 | Power-down bit for configured mode |
| reqRefSel | input | 2 | Reference selection code for configured mode |
| csN | output | 2 | Chip selects, active low |
| fs | output | 1 | Frame sync, low during a frame |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data to the DAC |
| done | output | 1 | One-cycle pulse at the end of a request |

## Verification
The hardest case is a request that lands exactly on the done cycle, when the sequencer leaves one request and may take the next on the same edge. The bench holds reqValid high across the end of a request so that the next one is taken there, and checks that no idle cycle is inserted. A second hard case is a request arriving while a frame is running. The bench drives reqValid high mid-frame with a different word and confirms, cycle by cycle, that the frame in progress and the following idle state are unchanged. Configured split requests close out the corners: the byte pause then falls inside both frames of a back-to-back pair.

// File: rtl/dacHostPkg.sv
package dacHostPkg;

  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_CSSU = 3'd1,
    PH_FSSU = 3'd2,
    PH_LOW  = 3'd3,
    PH_HIGH = 3'd4,
    PH_TAIL = 3'd5,
    PH_GAP  = 3'd6
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // take the request words
    logic loadNext;  // move the queued second word into the shifter
    logic shift;     // advance one bit (on a rising sclk edge)
  } dpStrobe_t;

  function automatic logic [WORD_W-1:0] ctrlFrame(input logic spd, input logic pwr,
                                                  input logic [1:0] refSel);
    ctrlFrame = {1'b1, spd, pwr, 1'b1, 10'b0, refSel};
  endfunction

  function automatic logic [WORD_W-1:0] dataFrame(input logic spd, input logic pwr,
                                                  input logic [11:0] code);
    dataFrame = {1'b0, spd, pwr, 1'b0, code};
  endfunction

endpackage

// File: rtl/dacHostCtrl.sv
module dacHostCtrl
  import dacHostPkg::*;
#(
  parameter int CS_LEAD_CYC  = 2,
  parameter int FS_LEAD_CYC  = 2,
  parameter int CLK_LOW_CYC  = 5,
  parameter int CLK_HIGH_CYC = 5,
  parameter int TAIL_CYC     = 2,
  parameter int FS_IDLE_CYC  = 5,
  parameter int BYTE_GAP_CYC = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqCfg,
  input  logic      reqSplit,
  output logic      reqReady,
  output dpStrobe_t strobe,
  output logic      fs,
  output logic      sclk,
  output logic      csActive,
  output logic      done
);

  localparam int M1 = (CS_LEAD_CYC > FS_LEAD_CYC) ? CS_LEAD_CYC : FS_LEAD_CYC;
  localparam int M2 = (CLK_LOW_CYC > TAIL_CYC) ? CLK_LOW_CYC : TAIL_CYC;
  localparam int M3 = (FS_IDLE_CYC > CLK_HIGH_CYC + BYTE_GAP_CYC) ? FS_IDLE_CYC
                                                                  : CLK_HIGH_CYC + BYTE_GAP_CYC;
  localparam int M12   = (M1 > M2) ? M1 : M2;
  localparam int MAXC  = (M12 > M3) ? M12 : M3;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int BIT_W = $clog2(WORD_W + 1);

  phase_e           phase, phaseNxt;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitCnt;
  logic             splitReg, pendReg;
  logic             lastCyc, doneNxt;
  int               phaseLen;

  always_comb begin
    case (phase)
      PH_CSSU: phaseLen = CS_LEAD_CYC;
      PH_FSSU: phaseLen = FS_LEAD_CYC;
      PH_LOW:  phaseLen = CLK_LOW_CYC;
      PH_HIGH: phaseLen = (splitReg && bitCnt == BIT_W'(WORD_W / 2))
                          ? CLK_HIGH_CYC + BYTE_GAP_CYC : CLK_HIGH_CYC;
      PH_TAIL: phaseLen = TAIL_CYC;
      PH_GAP:  phaseLen = FS_IDLE_CYC;
      default: phaseLen = 1;
    endcase
    lastCyc = (cnt == CNT_W'(phaseLen - 1));
  end

  always_comb begin
    phaseNxt = phase;
    strobe   = '0;
    doneNxt  = 1'b0;
    case (phase)
      PH_IDLE: if (reqValid) begin
        phaseNxt       = PH_CSSU;
        strobe.capture = 1'b1;
      end
      PH_CSSU: if (lastCyc) phaseNxt = PH_FSSU;
      PH_FSSU: if (lastCyc) phaseNxt = PH_LOW;
      PH_LOW: if (lastCyc) begin
        strobe.shift = 1'b1;
        phaseNxt     = (bitCnt == BIT_W'(WORD_W - 1)) ? PH_TAIL : PH_HIGH;
      end
      PH_HIGH: if (lastCyc) phaseNxt = PH_LOW;
      PH_TAIL: if (lastCyc) phaseNxt = PH_GAP;
      PH_GAP: if (lastCyc) begin
        if (pendReg) begin
          phaseNxt        = PH_CSSU;
          strobe.loadNext = 1'b1;
        end else begin
          phaseNxt = PH_IDLE;
          doneNxt  = 1'b1;
        end
      end
      default: phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      bitCnt   <= '0;
      splitReg <= 1'b0;
      pendReg  <= 1'b0;
      sclk     <= 1'b1;
      fs       <= 1'b1;
      csActive <= 1'b0;
      done     <= 1'b0;
    end else begin
      phase <= phaseNxt;
      cnt   <= (phaseNxt != phase || phase == PH_IDLE) ? '0 : cnt + 1'b1;
      if (phase == PH_FSSU) bitCnt <= '0;
      else if (strobe.shift) bitCnt <= bitCnt + 1'b1;
      if (strobe.capture) begin
        splitReg <= reqSplit;
        pendReg  <= reqCfg;
      end else if (strobe.loadNext) begin
        pendReg <= 1'b0;
      end
      sclk     <= (phaseNxt != PH_LOW);
      fs       <= !(phaseNxt inside {PH_FSSU, PH_LOW, PH_HIGH, PH_TAIL});
      csActive <= (phaseNxt inside {PH_CSSU, PH_FSSU, PH_LOW, PH_HIGH, PH_TAIL});
      done     <= doneNxt;
    end
  end

  assign reqReady = (phase == PH_IDLE);

  // checker state: falling sclk edges seen in the current frame
  logic       sclkQ;
  logic [4:0] fallCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ   <= 1'b1;
      fallCnt <= '0;
    end else begin
      sclkQ <= sclk;
      if (fs) fallCnt <= '0;
      else if (sclkQ && !sclk) fallCnt <= fallCnt + 1'b1;
    end
  end

  // R5
  frame_sixteen_falls_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fs) |-> fallCnt == 5'(WORD_W));

  // R4
  sclk_fall_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |-> (!fs && csActive));

  // R3
  fs_fall_after_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fs) |-> ($past(csActive) && csActive));

  // R7
  fs_cs_rise_together_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fs) |-> $fell(csActive));

  // R8
  done_after_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (fs && !csActive && reqReady));

endmodule

// File: rtl/dacHostData.sv
module dacHostData
  import dacHostPkg::*;
#(
  parameter int CS_COUNT = 2,
  localparam int SEL_W   = (CS_COUNT > 1) ? $clog2(CS_COUNT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              reqCfg,
  input  logic [SEL_W-1:0]  reqSel,
  input  logic [WORD_W-1:0] reqWord,
  input  logic              reqSpeed,
  input  logic              reqPower,
  input  logic [1:0]        reqRefSel,
  input  logic              csActive,
  input  logic              sclk,
  output logic              sdo,
  output logic [CS_COUNT-1:0] csN
);

  logic [WORD_W-1:0] shiftReg, nextWord;
  logic [SEL_W-1:0]  selReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      nextWord <= '0;
      selReg   <= '0;
    end else if (strobe.capture) begin
      selReg   <= reqSel;
      shiftReg <= reqCfg ? ctrlFrame(reqSpeed, reqPower, reqRefSel) : reqWord;
      nextWord <= dataFrame(reqSpeed, reqPower, reqWord[11:0]);
    end else if (strobe.loadNext) begin
      shiftReg <= nextWord;
    end else if (strobe.shift) begin
      shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
    end
  end

  assign sdo = shiftReg[WORD_W-1];

  for (genvar g = 0; g < CS_COUNT; g++) begin : gCs
    assign csN[g] = !(csActive && selReg == SEL_W'(g));
  end

  // R6
  sdo_stable_at_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |-> $stable(sdo));

  // R3
  one_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

endmodule

// File: rtl/dacSerialHost.sv
module dacSerialHost
  import dacHostPkg::*;
#(
  parameter int CS_LEAD_CYC  = 2,
  parameter int FS_LEAD_CYC  = 2,
  parameter int CLK_LOW_CYC  = 5,
  parameter int CLK_HIGH_CYC = 5,
  parameter int TAIL_CYC     = 2,
  parameter int FS_IDLE_CYC  = 5,
  parameter int BYTE_GAP_CYC = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqCfg,
  input  logic        reqSplit,
  input  logic        reqSel,
  input  logic [15:0] reqWord,
  input  logic        reqSpeed,
  input  logic        reqPower,
  input  logic [1:0]  reqRefSel,
  output logic [1:0]  csN,
  output logic        fs,
  output logic        sclk,
  output logic        sdo,
  output logic        done
);

  dpStrobe_t strobe;
  logic      csActive;

  dacHostCtrl #(
    .CS_LEAD_CYC (CS_LEAD_CYC),
    .FS_LEAD_CYC (FS_LEAD_CYC),
    .CLK_LOW_CYC (CLK_LOW_CYC),
    .CLK_HIGH_CYC(CLK_HIGH_CYC),
    .TAIL_CYC    (TAIL_CYC),
    .FS_IDLE_CYC (FS_IDLE_CYC),
    .BYTE_GAP_CYC(BYTE_GAP_CYC)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqCfg  (reqCfg),
    .reqSplit(reqSplit),
    .reqReady(reqReady),
    .strobe  (strobe),
    .fs      (fs),
    .sclk    (sclk),
    .csActive(csActive),
    .done    (done)
  );

  dacHostData #(.CS_COUNT(2)) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqCfg   (reqCfg),
    .reqSel   (reqSel),
    .reqWord  (reqWord),
    .reqSpeed (reqSpeed),
    .reqPower (reqPower),
    .reqRefSel(reqRefSel),
    .csActive (csActive),
    .sclk     (sclk),
    .sdo      (sdo),
    .csN      (csN)
  );

endmodule

// File: tb/test_dacSerialHost.sv
`timescale 1ns/1ps
module test_dacSerialHost;

  localparam int CSL = 2, FSL = 2, CLO = 5, CHI = 5, TAIL = 2, FSI = 5, GAP = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqCfg = 1'b0, reqSplit = 1'b0, reqSel = 1'b0;
  logic [15:0] reqWord = '0;
  logic        reqSpeed = 1'b0, reqPower = 1'b0;
  logic [1:0]  reqRefSel = '0;
  logic        reqReady, fs, sclk, sdo, done;
  logic [1:0]  csN;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dacSerialHost #(
    .CS_LEAD_CYC(CSL), .FS_LEAD_CYC(FSL), .CLK_LOW_CYC(CLO), .CLK_HIGH_CYC(CHI),
    .TAIL_CYC(TAIL), .FS_IDLE_CYC(FSI), .BYTE_GAP_CYC(GAP)
  ) i_dacSerialHost (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqCfg(reqCfg),
    .reqSplit(reqSplit), .reqSel(reqSel), .reqWord(reqWord), .reqSpeed(reqSpeed),
    .reqPower(reqPower), .reqRefSel(reqRefSel), .csN(csN), .fs(fs), .sclk(sclk),
    .sdo(sdo), .done(done)
  );

  // expected port values for one cycle; tags give the requirement number
  typedef struct {
    logic [1:0] csN;
    logic fs, sclk, sdo, done, ready;
    int tGen, tSclk, tSdo;
  } exp_t;

  exp_t q[$];
  exp_t cur;

  function automatic exp_t mk(logic [1:0] c, logic f, logic s, logic d, logic dn,
                              logic rd, int tg, int ts, int td);
    exp_t e;
    e.csN = c; e.fs = f; e.sclk = s; e.sdo = d; e.done = dn; e.ready = rd;
    e.tGen = tg; e.tSclk = ts; e.tSdo = td;
    return e;
  endfunction

  // R1 idle values
  function automatic exp_t idleExp();
    return mk(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1, 1, 1);
  endfunction

  // builds the expected waveform of one frame: R3 lead, R4 fs lead, R5/R6 bits,
  // R10 byte pause, R7 tail, R8 idle pulse and done, R9 words in configured mode
  task automatic pushFrame(input logic [15:0] w, input logic sel, input bit split,
                           input bit last, input bit cfg);
    logic [1:0] c = sel ? 2'b01 : 2'b10;
    int dTag = cfg ? 9 : 6;
    repeat (CSL) q.push_back(mk(c, 1, 1, w[15], 0, 0, 3, 3, 3));
    repeat (FSL) q.push_back(mk(c, 0, 1, w[15], 0, 0, 4, 4, 4));
    for (int k = 0; k < 16; k++) begin
      repeat (CLO) q.push_back(mk(c, 0, 0, w[15-k], 0, 0, 5, 5, dTag));
      if (k < 15) begin
        int hl = (split && k == 7) ? CHI + GAP : CHI;
        repeat (hl) q.push_back(mk(c, 0, 1, w[14-k], 0, 0, 5,
                                   (split && k == 7) ? 10 : 5, dTag));
      end
    end
    repeat (TAIL) q.push_back(mk(c, 0, 1, 0, 0, 0, 7, 7, 7));
    repeat (FSI) q.push_back(mk(2'b11, 1, 1, 0, 0, 0, 8, 8, 8));
    if (last) q.push_back(mk(2'b11, 1, 1, 0, 1, 1, 8, 8, 8));
  endtask

  // reference model, advanced on every clock
  always @(posedge clk) begin
    if (!rstN) begin
      q.delete();
      cur = idleExp();
    end else begin
      if (cur.ready && reqValid) begin  // R2 acceptance only when idle
        if (reqCfg) begin
          pushFrame({1'b1, reqSpeed, reqPower, 1'b1, 10'b0, reqRefSel}, reqSel, reqSplit, 0, 1);
          pushFrame({1'b0, reqSpeed, reqPower, 1'b0, reqWord[11:0]}, reqSel, reqSplit, 1, 1);
        end else begin
          pushFrame(reqWord, reqSel, reqSplit, 1, 0);
        end
      end
      if (q.size() > 0) cur = q.pop_front();
      else cur = idleExp();
    end
  end

  task automatic chk(input string name, input int tag, input logic [1:0] act,
                     input logic [1:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL R%0d %s at cycle %0d: actual=%b expected=%b", tag, name, cycles, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN && cycles > 3) begin
      chk("csN",      cur.tGen,  csN,              cur.csN);
      chk("fs",       cur.tGen,  {1'b0, fs},       {1'b0, cur.fs});
      chk("sclk",     cur.tSclk, {1'b0, sclk},     {1'b0, cur.sclk});
      chk("sdo",      cur.tSdo,  {1'b0, sdo},      {1'b0, cur.sdo});
      chk("done",     8,         {1'b0, done},     {1'b0, cur.done});
      chk("reqReady", 2,         {1'b0, reqReady}, {1'b0, cur.ready});
    end
  end

  task automatic issue(input bit cfg, input bit split, input logic sel, input logic [15:0] w,
                       input logic spd, input logic pwr, input logic [1:0] rs);
    @(negedge clk);
    reqCfg = cfg; reqSplit = split; reqSel = sel; reqWord = w;
    reqSpeed = spd; reqPower = pwr; reqRefSel = rs; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitQuiet();
    @(negedge clk);
    while (q.size() > 0 || !cur.ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    cur = idleExp();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("csN reset",   1, csN,              2'b11);
    chk("fs reset",    1, {1'b0, fs},       2'b01);
    chk("sclk reset",  1, {1'b0, sclk},     2'b01);
    chk("sdo reset",   1, {1'b0, sdo},      2'b00);
    chk("ready reset", 1, {1'b0, reqReady}, 2'b01);
    chk("done reset",  1, {1'b0, done},     2'b00);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R6 raw word to chip select 0
    issue(0, 0, 1'b0, 16'hA5C3, 0, 0, 2'b00);
    waitQuiet();
    // R10 split raw word to chip select 1
    issue(0, 1, 1'b1, 16'h5A3C, 0, 0, 2'b00);
    waitQuiet();
    // R9 configured: fast, powered, reference code 2, full-scale code
    issue(1, 0, 1'b0, 16'h0FFF, 1, 0, 2'b10);
    waitQuiet();
    // R2 request while busy must be ignored
    issue(0, 0, 1'b0, 16'h8001, 0, 0, 2'b00);
    repeat (20) @(negedge clk);
    reqWord = 16'hFFFF; reqSel = 1'b1; reqValid = 1'b1;
    repeat (20) @(negedge clk);
    reqValid = 1'b0;
    waitQuiet();
    // R2/R8 back-to-back: second taken on the done cycle; R9/R10 configured split
    issue(1, 1, 1'b1, 16'hF001, 0, 1, 2'b01);
    issue(0, 1, 1'b0, 16'h7FFE, 0, 0, 2'b00);
    waitQuiet();
    finish();
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog expired: actual=running expected=finished");
    finish();
  end

endmodule